// File: doc/BRIEF.md
# Byte-Masked Page Access Controller for One-Time-Programmable Storage

This block is a small register-mapped controller that sits in front of a one-time-programmable storage array of 512 pages. Each page is 128 bits wide. A bus master fills four 32-bit data registers and a 16-bit byte-enable mask. It then writes a control word that holds a page number and a store flag. That write starts the transfer at once. Every enabled byte is copied between the data registers and the chosen page: into the page when the store flag is set, and out of it otherwise. Disabled bytes are left as they were on the destination side.

Each transfer finishes in the same cycle as the control write. It sets a sticky done flag in the status register, and a level interrupt follows that flag. Each register accepts one access width only. Accesses of an illegal size and accesses to unmapped offsets are refused with a one-cycle error pulse and a cause code. In this model the array is an internal register file. At reset it is cleared, except page 0, which is loaded with a fixed identifier pattern.

Top module: `otpc_top`

## Requirements
- R1: After reset, control, byte-enable, status and the four data registers read as zero, timing reads 0x00001485, and irq is low.
- R2: At reset, byte k (k = 0..15) of page 0 holds 0xA0 | k, and every other page holds all zeros.
- R3: Register map on a 6-bit byte offset. Control is at 0x00, byte-enable at 0x04 and status at 0x08; these take only half-word accesses (size code 01), and their reads are zero-extended. Timing is at 0x0C and data0..data3 are at 0x10, 0x14, 0x18 and 0x1C; these take only word accesses (size code 10). A legal read returns its data with bus_rvalid in the cycle after the request.
- R4: A control write keeps only the bits in 0x39FF, and all other bits read back as zero. Bits 8:0 give the page number, and bit 11 is the store flag.
- R5: A control write with bit 11 clear loads the page. For each set bit k of byte-enable, page byte k is copied into data register k/4 at bits 8*(k%4)+7:8*(k%4). Data bytes whose enable bit is clear keep their value.
- R6: A control write with bit 11 set stores data register bytes into the page. Only the enabled bytes are written, using the same byte numbering as R5, and all other page bytes keep their value.
- R7: Every control write that starts a transfer sets status bit 0 (done), and irq stays high for as long as that bit is set.
- R8: Status bits are write-one-to-clear. Writing a 0 to a bit leaves that bit unchanged.
- R9: Timing is a plain 32-bit read/write register. Its value has no effect on transfers.
- R10: A size code other than 01 or 10 is reported as error code 01, even at an unmapped offset. With a legal size, an offset that is not one of the eight listed is reported as code 10. A legal size that does not match the register's width is reported as code 01.
- R11: An illegal access makes bus_err high for exactly the cycle after the request. It returns zero read data, changes no register and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_rvalid | output | 1 | Read data valid |
| rsp_err | output | 1 | One-cycle pulse when an access was refused |
| rsp_err_code | output | 2 | 01 size error, 10 unmapped offset |
| irq | output | 1 | High while the done flag is set |

## Verification
The bench uses mixed byte-enable masks, so a design that ignored the mask, or placed bytes at the wrong positions inside the 32-bit words, would return foreign bytes in data0. It sends a byte-size access to an unmapped offset; if the unmapped check ran first, the error code would come back as 10 instead of 01. It also sends a wrong-width write to the control register, and a design that still launched on that write would raise irq. Write-one-to-clear is tested with a zero write, which would wrongly clear done if the status register were plainly writable. The 0x39FF mask and the page-0 identifier are both read back through the bus.

// File: rtl/otpc_pkg.sv
package otpc_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int PAGE_W     = PAGE_BYTES * 8;
  localparam int DWORDS     = PAGE_BYTES / 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'b00,
    ERR_SIZE     = 2'b01,
    ERR_UNMAPPED = 2'b10
  } err_code_e;

  typedef enum logic [2:0] {
    IDX_CTRL   = 3'd0,
    IDX_BEN    = 3'd1,
    IDX_STATUS = 3'd2,
    IDX_TIMING = 3'd3,
    IDX_DATA0  = 3'd4,
    IDX_DATA1  = 3'd5,
    IDX_DATA2  = 3'd6,
    IDX_DATA3  = 3'd7
  } reg_idx_e;

  // Byte-granular merge: enabled bytes come from src, others stay from dst.
  function automatic logic [PAGE_W-1:0] merge_bytes(
    input logic [PAGE_W-1:0]     dst,
    input logic [PAGE_W-1:0]     src,
    input logic [PAGE_BYTES-1:0] en
  );
    logic [PAGE_W-1:0] res;
    res = dst;
    for (int k = 0; k < PAGE_BYTES; k++)
      if (en[k]) res[8*k +: 8] = src[8*k +: 8];
    return res;
  endfunction

  // Identifier preloaded into page 0: byte k = 0xA0 | k.
  function automatic logic [PAGE_W-1:0] page0_ident();
    logic [PAGE_W-1:0] res;
    for (int k = 0; k < PAGE_BYTES; k++)
      res[8*k +: 8] = 8'hA0 | 8'(k);
    return res;
  endfunction

  // Access width each register index demands.
  function automatic acc_size_e width_of(input logic [2:0] idx);
    return (idx <= 3'd2) ? SZ_HALF : SZ_WORD;
  endfunction
endpackage

// File: rtl/otpc_access_decode.sv
module otpc_access_decode
  import otpc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic [1:0]        bad_code,
  output logic [2:0]        reg_idx
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = 4;

  logic size_legal;
  logic offset_mapped;
  logic width_match;

  assign reg_idx       = req_addr[IDX_MSB:IDX_LSB];
  assign size_legal    = (req_size == SZ_HALF) || (req_size == SZ_WORD);
  assign offset_mapped = (req_addr[IDX_LSB-1:0] == '0) &&
                         (req_addr[ADDR_W-1:IDX_MSB+1] == '0);
  assign width_match   = (req_size == width_of(reg_idx));

  always_comb begin
    acc_ok   = 1'b0;
    acc_bad  = 1'b0;
    bad_code = ERR_NONE;
    if (req_valid) begin
      if (!size_legal) begin
        acc_bad  = 1'b1;
        bad_code = ERR_SIZE;
      end else if (!offset_mapped) begin
        acc_bad  = 1'b1;
        bad_code = ERR_UNMAPPED;
      end else if (!width_match) begin
        acc_bad  = 1'b1;
        bad_code = ERR_SIZE;
      end else begin
        acc_ok = 1'b1;
      end
    end
  end

  // R10
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_size == SZ_BYTE || req_size == SZ_RSVD)) |->
      (acc_bad && bad_code == ERR_SIZE));

  // R10
  ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ok && acc_bad));
endmodule

// File: rtl/otpc_page_store.sv
module otpc_page_store
  import otpc_pkg::*;
#(
  parameter int PAGES   = 512,
  parameter int PAGE_AW = $clog2(PAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PAGE_AW-1:0]    rd_page,
  output logic [PAGE_W-1:0]     rd_data,
  input  logic                  wr_en,
  input  logic [PAGE_AW-1:0]    wr_page,
  input  logic [PAGE_W-1:0]     wr_data,
  input  logic [PAGE_BYTES-1:0] wr_mask
);
  logic [PAGE_W-1:0] mem [PAGES];

  assign rd_data = mem[rd_page];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        mem[p] <= (p == 0) ? page0_ident() : '0;
    end else if (wr_en) begin
      mem[wr_page] <= merge_bytes(mem[wr_page], wr_data, wr_mask);
    end
  end

  // R6
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_page == wr_page));
endmodule

// File: rtl/otpc_reg_bank.sv
module otpc_reg_bank
  import otpc_pkg::*;
#(
  parameter int           PAGE_AW    = 9,
  parameter logic [15:0]  CTRL_KEEP  = 16'h39FF,
  parameter int           STORE_BIT  = 11,
  parameter logic [31:0]  TIMING_RST = 32'h0000_1485
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               bad_access,
  input  logic [2:0]         reg_idx,
  input  logic [31:0]        wdata,
  input  logic [PAGE_W-1:0]  page_rdata,
  output logic               op_launch,
  output logic               op_store,
  output logic [PAGE_AW-1:0] op_page,
  output logic [PAGE_W-1:0]  data_q,
  output logic [PAGE_BYTES-1:0] ben_q,
  output logic [31:0]        rd_value,
  output logic               irq
);
  localparam int DONE_BIT = 0;

  logic [15:0] ctrl_q;
  logic [15:0] status_q;
  logic [31:0] timing_q;
  logic        status_w1c;

  // Named events for the page transfer.
  assign op_launch  = wr_en && (reg_idx == IDX_CTRL);
  assign op_store   = op_launch && wdata[STORE_BIT];
  assign op_page    = wdata[PAGE_AW-1:0];
  assign status_w1c = wr_en && (reg_idx == IDX_STATUS);
  assign irq        = status_q[DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ben_q  <= '0;
      timing_q <= TIMING_RST;
    end else if (wr_en) begin
      case (reg_idx)
        IDX_CTRL:   ctrl_q   <= wdata[15:0] & CTRL_KEEP;
        IDX_BEN:    ben_q    <= wdata[PAGE_BYTES-1:0];
        IDX_TIMING: timing_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (op_launch) begin
      status_q[DONE_BIT] <= 1'b1;
    end else if (status_w1c) begin
      status_q <= status_q & ~wdata[15:0];
    end
  end

  // Data registers: bus writes per word, page loads per byte.
  for (genvar w = 0; w < DWORDS; w++) begin : g_dword
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[32*w +: 32] <= '0;
      end else if (wr_en && reg_idx == 3'(int'(IDX_DATA0) + w)) begin
        data_q[32*w +: 32] <= wdata;
      end else if (op_launch && !op_store) begin
        data_q[32*w +: 32] <= merge_bytes(data_q, page_rdata, ben_q)[32*w +: 32];
      end
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_CTRL:   rd_value = {16'h0, ctrl_q};
      IDX_BEN:    rd_value = {16'h0, ben_q};
      IDX_STATUS: rd_value = {16'h0, status_q};
      IDX_TIMING: rd_value = timing_q;
      default:    rd_value = data_q[32*(reg_idx - 3'd4) +: 32];
    endcase
  end

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_launch |=> irq);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w1c && wdata[DONE_BIT]) |=> !irq);

  // R5
  zero_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_launch && !op_store && ben_q == '0) |=> $stable(data_q));

  // R11
  bad_access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> ($stable(data_q) && $stable(ctrl_q) && $stable(ben_q) &&
                    $stable(status_q) && $stable(timing_q)));
endmodule

// File: rtl/otpc_top.sv
module otpc_top
  import otpc_pkg::*;
#(
  parameter int          PAGES      = 512,
  parameter int          ADDR_W     = 6,
  parameter logic [15:0] CTRL_KEEP  = 16'h39FF,
  parameter int          STORE_BIT  = 11,
  parameter logic [31:0] TIMING_RST = 32'h0000_1485
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_rvalid,
  output logic              rsp_err,
  output logic [1:0]        rsp_err_code,
  output logic              irq
);
  localparam int PAGE_AW = $clog2(PAGES);

  logic                  acc_ok, acc_bad;
  logic [1:0]            bad_code;
  logic [2:0]            reg_idx;
  logic                  wr_en, rd_en;
  logic                  op_launch, op_store;
  logic [PAGE_AW-1:0]    op_page;
  logic [PAGE_W-1:0]     data_q, page_rdata;
  logic [PAGE_BYTES-1:0] ben_q;
  logic [31:0]           rd_value;

  assign wr_en = acc_ok && req_write;
  assign rd_en = acc_ok && !req_write;

  otpc_access_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .acc_ok(acc_ok), .acc_bad(acc_bad), .bad_code(bad_code), .reg_idx(reg_idx)
  );

  otpc_reg_bank #(
    .PAGE_AW(PAGE_AW), .CTRL_KEEP(CTRL_KEEP),
    .STORE_BIT(STORE_BIT), .TIMING_RST(TIMING_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .bad_access(acc_bad), .reg_idx(reg_idx),
    .wdata(req_wdata), .page_rdata(page_rdata),
    .op_launch(op_launch), .op_store(op_store), .op_page(op_page),
    .data_q(data_q), .ben_q(ben_q), .rd_value(rd_value), .irq(irq)
  );

  otpc_page_store #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_page(op_page), .rd_data(page_rdata),
    .wr_en(op_store), .wr_page(op_page), .wr_data(data_q), .wr_mask(ben_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata    <= '0;
      rsp_rvalid   <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_err_code <= ERR_NONE;
    end else begin
      rsp_rdata    <= rd_en ? rd_value : '0;
      rsp_rvalid   <= rd_en;
      rsp_err      <= acc_bad;
      rsp_err_code <= bad_code;
    end
  end

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (rsp_err && rsp_rdata == '0 && !rsp_rvalid));

  // R11
  no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_bad |=> !rsp_err);

  // R3
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && acc_ok) |=> rsp_rvalid);
endmodule

// File: tb/tb_otpc_top.sv
module tb_otpc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_rvalid, rsp_err, irq;
  logic [1:0]  rsp_err_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  otpc_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_rvalid(rsp_rvalid), .rsp_err(rsp_err),
    .rsp_err_code(rsp_err_code), .irq(irq)
  );

  localparam logic [1:0] H = 2'b01, W = 2'b10, B = 2'b00;
  // {write, addr, size, wdata, expected rdata, expected err, expected code}
  localparam int NV = 26;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 6'h04, H, 32'h0000FFFF, 32'h0, 1'b0, 2'b00}, // R3 ben all
    {1'b1, 6'h00, H, 32'h00000000, 32'h0, 1'b0, 2'b00}, // R5 load page 0
    {1'b0, 6'h10, W, 32'h0, 32'hA3A2A1A0, 1'b0, 2'b00}, // R2 R5
    {1'b0, 6'h14, W, 32'h0, 32'hA7A6A5A4, 1'b0, 2'b00}, // R2
    {1'b0, 6'h1C, W, 32'h0, 32'hAFAEADAC, 1'b0, 2'b00}, // R2
    {1'b0, 6'h08, H, 32'h0, 32'h00000001, 1'b0, 2'b00}, // R7
    {1'b1, 6'h08, H, 32'h00000001, 32'h0, 1'b0, 2'b00}, // R8
    {1'b0, 6'h08, H, 32'h0, 32'h00000000, 1'b0, 2'b00}, // R8
    {1'b1, 6'h10, W, 32'h11223344, 32'h0, 1'b0, 2'b00},
    {1'b1, 6'h04, H, 32'h00000003, 32'h0, 1'b0, 2'b00},
    {1'b1, 6'h00, H, 32'h00000805, 32'h0, 1'b0, 2'b00}, // R6 store page 5
    {1'b1, 6'h10, W, 32'h00000000, 32'h0, 1'b0, 2'b00},
    {1'b1, 6'h04, H, 32'h0000FFFF, 32'h0, 1'b0, 2'b00},
    {1'b1, 6'h00, H, 32'h00000005, 32'h0, 1'b0, 2'b00}, // load page 5
    {1'b0, 6'h10, W, 32'h0, 32'h00003344, 1'b0, 2'b00}, // R6 masked store
    {1'b0, 6'h00, H, 32'h0, 32'h00000005, 1'b0, 2'b00}, // R4
    {1'b1, 6'h00, H, 32'h0000FFFF, 32'h0, 1'b0, 2'b00},
    {1'b0, 6'h00, H, 32'h0, 32'h000039FF, 1'b0, 2'b00}, // R4 keep mask
    {1'b1, 6'h00, W, 32'h00000000, 32'h0, 1'b1, 2'b01}, // R10 wrong width
    {1'b0, 6'h0C, H, 32'h0, 32'h0, 1'b1, 2'b01},        // R10
    {1'b0, 6'h20, W, 32'h0, 32'h0, 1'b1, 2'b10},        // R10 unmapped
    {1'b0, 6'h21, B, 32'h0, 32'h0, 1'b1, 2'b01},        // R10 priority
    {1'b0, 6'h02, H, 32'h0, 32'h0, 1'b1, 2'b10},        // R10 misaligned
    {1'b0, 6'h0C, W, 32'h0, 32'h00001485, 1'b0, 2'b00}, // R1 timing
    {1'b1, 6'h0C, W, 32'hDEADBEEF, 32'h0, 1'b0, 2'b00}, // R9
    {1'b0, 6'h0C, W, 32'h0, 32'hDEADBEEF, 1'b0, 2'b00}  // R9
  };

  logic [31:0] got_d;
  logic        got_e, got_v;
  logic [1:0]  got_c;

  task automatic xfer(input logic wr, input logic [5:0] a, input logic [1:0] s,
                      input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got_d = rsp_rdata; got_e = rsp_err; got_c = rsp_err_code; got_v = rsp_rvalid;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input logic [5:0] a, input logic [1:0] s,
                          input logic [31:0] exp, input string req);
    xfer(1'b0, a, s, 32'h0);
    check(got_d == exp && got_v && !got_e, req, got_d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      xfer(v[75], v[74:69], v[68:67], v[66:35]);
      if (v[75] || v[2])
        check(got_e == v[2] && got_c == v[1:0], "R10/R11 vec", {30'h0, got_c}, {30'h0, v[1:0]});
      else
        check(got_d == v[34:3] && !got_e, "R3 vec", got_d, v[34:3]);
    end

    // R1: reset values
    do_reset();
    @(negedge clk);
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    rd_check(6'h00, H, 32'h0, "R1 ctrl");
    rd_check(6'h04, H, 32'h0, "R1 ben");
    rd_check(6'h08, H, 32'h0, "R1 status");
    rd_check(6'h0C, W, 32'h00001485, "R1 timing");
    for (int w = 0; w < 4; w++) rd_check(6'(16 + 4*w), W, 32'h0, "R1 data");

    // R11: illegal accesses change nothing and launch nothing
    xfer(1'b1, 6'h10, W, 32'hFFFFFFFF);
    xfer(1'b1, 6'h10, H, 32'h12345678);
    check(got_e && got_d == 32'h0, "R11 err rdata", got_d, 32'h0);
    @(negedge clk);
    check(!rsp_err, "R11 single pulse", {31'h0, rsp_err}, 32'h0);
    rd_check(6'h10, W, 32'hFFFFFFFF, "R11 data hold");
    xfer(1'b1, 6'h00, W, 32'h00000000);
    check(irq == 1'b0, "R11 no launch", {31'h0, irq}, 32'h0);

    // R5: masked load keeps disabled bytes; R2 page 0 byte 0 only
    xfer(1'b1, 6'h04, H, 32'h00000001);
    xfer(1'b1, 6'h00, H, 32'h00000000);
    rd_check(6'h10, W, 32'hFFFFFFA0, "R5 masked load");
    check(irq == 1'b1, "R7 irq set", {31'h0, irq}, 32'h1);
    // R8: writing zero keeps done
    xfer(1'b1, 6'h08, H, 32'h00000000);
    check(irq == 1'b1, "R8 zero write", {31'h0, irq}, 32'h1);
    xfer(1'b1, 6'h08, H, 32'h0000FFFF);
    check(irq == 1'b0, "R8 clear", {31'h0, irq}, 32'h0);

    // R2: other pages read zero; R9 odd timing value has no effect
    xfer(1'b1, 6'h0C, W, 32'h00000000);
    xfer(1'b1, 6'h04, H, 32'h0000FFFF);
    xfer(1'b1, 6'h00, H, 32'h00000107);
    rd_check(6'h10, W, 32'h0, "R2 page 0x107 zero");
    rd_check(6'h1C, W, 32'h0, "R2 page 0x107 zero");

    // R6: store with upper-byte mask then load back
    xfer(1'b1, 6'h1C, W, 32'hCAFEF00D);
    xfer(1'b1, 6'h04, H, 32'h0000C000);
    xfer(1'b1, 6'h00, H, 32'h000009FF);
    xfer(1'b1, 6'h1C, W, 32'h0);
    xfer(1'b1, 6'h04, H, 32'h0000FFFF);
    xfer(1'b1, 6'h00, H, 32'h000001FF);
    rd_check(6'h1C, W, 32'hCAFE0000, "R6 top bytes store R9");

    done_run = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule